// File: doc/BRIEF.md
# Two-Register Packed-Index Table Expander

This datapath expands a vector of packed 2-bit indices into two full destination vectors of table entries. A 512-bit lookup table is viewed as sixteen 32-bit words, of which a 2-bit index can reach only words 0 to 3. Each result element is the low bits of the selected word, truncated to the element width, which is 8, 16 or 32 bits. Every element of both destinations is written, and no element is masked off.

The index vector of VL bits is split into segments. One segment supplies the indices for both destinations, and a 3-bit immediate chooses which segment, modulo the number of segments. That number is one quarter of the element width. The operation also produces the register numbers for the two writes. In the adjacent form they are an even register and the one after it. In the spaced form they are a register and the one eight above it, confined to the low half of each 16-register bank. Encodings that are not allowed raise an undefined flag and produce no write.

The operation takes a fixed single cycle. A start pulse is followed on the next cycle by a done pulse, together with the two results and their register numbers. The latency never depends on table contents or index values.

Top module: `pidx_expander`

## Requirements
- R1: Every cycle with `start_i` high is followed, on the next cycle only, by `done_o` high; `done_o` is never high on a cycle that does not follow a start.
- R2: Size code 2'b11 gives `undef_o` high and `wr_en_o` low with the done pulse.
- R3: With `strided_i`=1, size code 2'b10 (32-bit elements) also gives `undef_o` high and `wr_en_o` low.
- R4: Any other combination gives `wr_en_o` high and `undef_o` low with the done pulse.
- R5: The element width is 8 << size code. For destination r (0 = `res0_o`, 1 = `res1_o`) and element e, the 2-bit index is `src_i[2*((s*2+r)*(VL/width)+e) +: 2]`. Element e occupies `res[e*width +: width]` and equals the low width bits of table word idx, which is `table_i[32*idx +: 32]`.
- R6: The segment s is `seg_imm_i` modulo width/4. That modulus is 2 for 8-bit, 4 for 16-bit and 8 for 32-bit elements, so immediates that agree modulo that count give identical results.
- R7: With `strided_i`=0, `dst0_o` = {`dst_field_i[3:0]`, 0} and `dst1_o` = `dst0_o` + 1; `dst_field_i[4]` has no effect.
- R8: With `strided_i`=1, `dst0_o` = {`dst_field_i[4]`, 0, `dst_field_i[2:0]`} and `dst1_o` = `dst0_o` + 8; `dst_field_i[3]` has no effect.
- R9: Table words 4 to 15 (`table_i[511:128]`) have no effect on the results.
- R10: During and right after reset, `done_o`, `wr_en_o` and `undef_o` are low.
- R11: When `undef_o` is high, both results and both register numbers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation with the inputs of this cycle |
| table_i | input | 512 | Lookup table, word i at bits 32i+31:32i |
| src_i | input | VL | Packed 2-bit index vector |
| size_i | input | 2 | Element size code (00=8, 01=16, 10=32, 11 reserved) |
| seg_imm_i | input | 3 | Segment immediate |
| strided_i | input | 1 | 0 = adjacent register pair, 1 = pair spaced by eight |
| dst_field_i | input | 5 | Destination register field |
| done_o | output | 1 | Operation finished (one cycle after start) |
| wr_en_o | output | 1 | Both destinations are to be written |
| undef_o | output | 1 | Encoding not allowed, no write |
| dst0_o | output | 5 | First destination register number |
| dst1_o | output | 5 | Second destination register number |
| res0_o | output | VL | First destination value |
| res1_o | output | VL | Second destination value |

## Verification
On every cycle, the assertions check the fixed one-cycle latency and the legality decode for the reserved and spaced-form size codes. They also check that the register pair spacing matches the form, and that an undefined operation leaves zero results. The bench scenarios alone show that each element holds the right table word. These cover the segment arithmetic for every legal size, immediate and form, the wraparound of the immediate, and that the upper table words and ignored field bits have no effect.

// File: rtl/pidx_pkg.sv
package pidx_pkg;

    localparam int TBL_W   = 512;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 2;
    localparam int N_REACH = 1 << IDX_W;
    localparam int REG_W   = 5;
    localparam int N_DST   = 2;
    localparam int N_SIZES = 3;
    localparam int STRIDE_FAR = 8;

    typedef enum logic [1:0] {
        SZ_8    = 2'd0,
        SZ_16   = 2'd1,
        SZ_32   = 2'd2,
        SZ_RSVD = 2'd3
    } esz_e;

    typedef logic [N_REACH-1:0][WORD_W-1:0] reach_t;

    typedef struct packed {
        logic             legal;
        logic [REG_W-1:0] dst0;
        logic [REG_W-1:0] dst1;
    } dec_t;

endpackage

// File: rtl/pidx_decode.sv
module pidx_decode
    import pidx_pkg::*;
(
    input  logic [1:0]       size_i,
    input  logic             strided_i,
    input  logic [REG_W-1:0] field_i,
    output dec_t             dec_o
);

    esz_e sz;
    assign sz = esz_e'(size_i);

    always_comb begin
        dec_o = '0;
        if (strided_i) begin
            dec_o.legal = (sz == SZ_8) || (sz == SZ_16);
            dec_o.dst0  = {field_i[4], 1'b0, field_i[2:0]};
            dec_o.dst1  = {field_i[4], 1'b1, field_i[2:0]};
        end else begin
            dec_o.legal = (sz != SZ_RSVD);
            dec_o.dst0  = {field_i[3:0], 1'b0};
            dec_o.dst1  = {field_i[3:0], 1'b1};
        end
    end

endmodule

// File: rtl/pidx_gather.sv
module pidx_gather
    import pidx_pkg::*;
#(
    parameter int VL    = 256,
    parameter int R_IDX = 0
) (
    input  reach_t          words_i,
    input  logic [VL-1:0]   src_i,
    input  logic [1:0]      size_i,
    input  logic [2:0]      imm_i,
    output logic [VL-1:0]   res_o
);

    logic [N_SIZES-1:0][VL-1:0] var_res;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
        localparam int ES   = 8 << g;
        localparam int NE   = VL / ES;
        localparam int IB   = IDX_W * NE;
        localparam int NSEG = ES / (IDX_W * N_DST);

        logic [3:0]    k;
        logic [IB-1:0] chunk;

        assign k     = {imm_i & 3'(NSEG - 1), 1'(R_IDX)};
        assign chunk = IB'(src_i >> (32'(k) * IB));

        for (genvar e = 0; e < NE; e++) begin : g_el
            assign var_res[g][e*ES +: ES] = words_i[chunk[IDX_W*e +: IDX_W]][ES-1:0];
        end
    end

    always_comb begin
        case (esz_e'(size_i))
            SZ_8:    res_o = var_res[0];
            SZ_16:   res_o = var_res[1];
            SZ_32:   res_o = var_res[2];
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/pidx_expander.sv
module pidx_expander
    import pidx_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TBL_W-1:0] table_i,
    input  logic [VL-1:0]    src_i,
    input  logic [1:0]       size_i,
    input  logic [2:0]       seg_imm_i,
    input  logic             strided_i,
    input  logic [REG_W-1:0] dst_field_i,
    output logic             done_o,
    output logic             wr_en_o,
    output logic             undef_o,
    output logic [REG_W-1:0] dst0_o,
    output logic [REG_W-1:0] dst1_o,
    output logic [VL-1:0]    res0_o,
    output logic [VL-1:0]    res1_o
);

    localparam int REACH_BITS = N_REACH * WORD_W;

    reach_t words;
    logic   unused_tbl_hi;
    dec_t   dec;

    assign words         = table_i[REACH_BITS-1:0];
    assign unused_tbl_hi = ^table_i[TBL_W-1:REACH_BITS];

    pidx_decode u_dec (
        .size_i    (size_i),
        .strided_i (strided_i),
        .field_i   (dst_field_i),
        .dec_o     (dec)
    );

    logic [N_DST-1:0][VL-1:0] gres;

    for (genvar r = 0; r < N_DST; r++) begin : g_dst
        pidx_gather #(.VL(VL), .R_IDX(r)) u_gather (
            .words_i (words),
            .src_i   (src_i),
            .size_i  (size_i),
            .imm_i   (seg_imm_i),
            .res_o   (gres[r])
        );
    end

    logic                     done_q, wr_q, undef_q;
    logic [REG_W-1:0]         dst0_q, dst1_q;
    logic [N_DST-1:0][VL-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            undef_q <= 1'b0;
            dst0_q  <= '0;
            dst1_q  <= '0;
            res_q   <= '0;
        end else begin
            done_q  <= start_i;
            wr_q    <= start_i & dec.legal;
            undef_q <= start_i & ~dec.legal;
            if (start_i) begin
                dst0_q <= dec.legal ? dec.dst0 : '0;
                dst1_q <= dec.legal ? dec.dst1 : '0;
                res_q  <= dec.legal ? gres : '0;
            end
        end
    end

    assign done_o  = done_q;
    assign wr_en_o = wr_q;
    assign undef_o = undef_q;
    assign dst0_o  = dst0_q;
    assign dst1_o  = dst1_q;
    assign res0_o  = res_q[0];
    assign res1_o  = res_q[1];

endmodule

// File: rtl/pidx_expander_chk.sv
module pidx_expander_chk #(
    parameter int VL = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [1:0]    size_i,
    input logic          strided_i,
    input logic          done_o,
    input logic          wr_en_o,
    input logic          undef_o,
    input logic [4:0]    dst0_o,
    input logic [4:0]    dst1_o,
    input logic [VL-1:0] res0_o,
    input logic [VL-1:0] res1_o
);

    p_done_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    p_no_stray_done_r1: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    p_rsvd_size_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && size_i == 2'b11) |=> (undef_o && !wr_en_o));

    p_strided_wide_r3: assert property (@(posedge clk) disable iff (rst)
        (start_i && strided_i && size_i == 2'b10) |=> (undef_o && !wr_en_o));

    p_legal_write_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && size_i != 2'b11 && !(strided_i && size_i == 2'b10))
        |=> (wr_en_o && !undef_o));

    p_adjacent_pair_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !strided_i && size_i != 2'b11)
        |=> (dst1_o == dst0_o + 5'd1 && !dst0_o[0]));

    p_spaced_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && strided_i && !size_i[1])
        |=> (dst1_o == dst0_o + 5'd8 && !dst0_o[3]));

    p_undef_zero_r11: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (res0_o == '0 && res1_o == '0 && dst0_o == '0 && dst1_o == '0));

endmodule

bind pidx_expander pidx_expander_chk #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .size_i    (size_i),
    .strided_i (strided_i),
    .done_o    (done_o),
    .wr_en_o   (wr_en_o),
    .undef_o   (undef_o),
    .dst0_o    (dst0_o),
    .dst1_o    (dst1_o),
    .res0_o    (res0_o),
    .res1_o    (res1_o)
);

// File: tb/sim_pidx_expander.sv
`timescale 1ns/1ps
module sim_pidx_expander;

    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [511:0]  tbl;
    logic [VL-1:0] src;
    logic [1:0]    sz;
    logic [2:0]    imm;
    logic          strd;
    logic [4:0]    fld;
    logic          done, wr_en, undef;
    logic [4:0]    d0, d1;
    logic [VL-1:0] r0, r1;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pidx_expander #(.VL(VL)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .table_i(tbl), .src_i(src),
        .size_i(sz), .seg_imm_i(imm), .strided_i(strd), .dst_field_i(fld),
        .done_o(done), .wr_en_o(wr_en), .undef_o(undef),
        .dst0_o(d0), .dst1_o(d1), .res0_o(r0), .res1_o(r1)
    );

    typedef struct packed {
        logic [1:0] vsz;
        logic [2:0] vimm;
        logic       vstrd;
        logic [4:0] vfld;
        logic [4:0] e0;
        logic [4:0] e1;
        logic       eu;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 1'b0, 5'h03, 5'd6,  5'd7,  1'b0},
        '{2'd1, 3'd5, 1'b0, 5'h1F, 5'd30, 5'd31, 1'b0},
        '{2'd2, 3'd7, 1'b0, 5'h10, 5'd0,  5'd1,  1'b0},
        '{2'd3, 3'd0, 1'b0, 5'h02, 5'd0,  5'd0,  1'b1},
        '{2'd0, 3'd3, 1'b1, 5'h15, 5'd21, 5'd29, 1'b0},
        '{2'd1, 3'd6, 1'b1, 5'h0A, 5'd2,  5'd10, 1'b0},
        '{2'd2, 3'd2, 1'b1, 5'h01, 5'd0,  5'd0,  1'b1},
        '{2'd3, 3'd4, 1'b1, 5'h07, 5'd0,  5'd0,  1'b1},
        '{2'd0, 3'd7, 1'b1, 5'h1F, 5'd23, 5'd31, 1'b0},
        '{2'd2, 3'd4, 1'b0, 5'h08, 5'd16, 5'd17, 1'b0}
    };

    function automatic logic [VL-1:0] ref_res(input logic [VL-1:0] s, input logic [511:0] t,
                                              input int size, input int im, input int r);
        int es, ne, seg, pos, idx;
        logic [VL-1:0] v;
        es  = 8 << size;
        ne  = VL / es;
        seg = im % (es / 4);
        v   = '0;
        for (int e = 0; e < ne; e++) begin
            pos = 2 * ((seg * 2 + r) * ne + e);
            idx = int'(s[pos +: 2]);
            for (int b = 0; b < es; b++) v[e*es + b] = t[idx*32 + b];
        end
        return v;
    endfunction

    function automatic logic [VL-1:0] rnd_vl();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [511:0] rnd_tbl();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] s, input logic [2:0] im,
                         input logic st, input logic [4:0] f);
        @(negedge clk);
        sz = s; imm = im; strd = st; fld = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic chk_results(input string req, input int s, input int im);
        logic [VL-1:0] x0, x1;
        x0 = ref_res(src, tbl, s, im, 0);
        x1 = ref_res(src, tbl, s, im, 1);
        chk(r0 == x0, req, "res0", r0, x0);
        chk(r1 == x1, req, "res1", r1, x1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [VL-1:0] a0, a1;
        rst = 1'b1; start = 1'b0; sz = '0; imm = '0; strd = 1'b0; fld = '0;
        tbl = rnd_tbl(); src = rnd_vl();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({done, wr_en, undef} == 3'b000, "R10", "flags in reset", VL'({done, wr_en, undef}), '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: no done without start
        chk(done == 1'b0, "R1", "idle done", VL'(done), '0);
        chk({wr_en, undef} == 2'b00, "R10", "flags after reset", VL'({wr_en, undef}), '0);

        // Vector table: decode, register numbers, results
        for (int i = 0; i < NV; i++) begin
            src = rnd_vl(); tbl = rnd_tbl();
            do_op(VECS[i].vsz, VECS[i].vimm, VECS[i].vstrd, VECS[i].vfld);
            chk(done == 1'b1, "R1", "done after start", VL'(done), VL'(1));
            chk(undef == VECS[i].eu, VECS[i].eu ? (VECS[i].vstrd ? "R3" : "R2") : "R4",
                "undef", VL'(undef), VL'(VECS[i].eu));
            chk(wr_en == !VECS[i].eu, "R4", "wr_en", VL'(wr_en), VL'(!VECS[i].eu));
            chk(d0 == VECS[i].e0 && d1 == VECS[i].e1, VECS[i].vstrd ? "R8" : "R7",
                "dst pair", VL'({d0, d1}), VL'({VECS[i].e0, VECS[i].e1}));
            if (VECS[i].eu)
                chk(r0 == '0 && r1 == '0, "R11", "zero results", r0 | r1, '0);
            else
                chk_results("R5", int'(VECS[i].vsz), int'(VECS[i].vimm));
        end

        @(negedge clk);
        chk(done == 1'b0, "R1", "done is one cycle only", VL'(done), '0);

        // R5/R6: every legal size, immediate and form against the reference
        for (int s = 0; s < 3; s++)
            for (int st = 0; st < 2; st++)
                for (int im = 0; im < 8; im++) begin
                    if (st == 1 && s == 2) continue;
                    src = rnd_vl(); tbl = rnd_tbl();
                    do_op(2'(s), 3'(im), 1'(st), 5'(im * 3));
                    chk_results("R6", s, im);
                end

        // R6: immediates equal modulo the segment count give equal results
        src = rnd_vl(); tbl = rnd_tbl();
        do_op(2'd0, 3'd1, 1'b0, 5'd0); a0 = r0; a1 = r1;
        do_op(2'd0, 3'd7, 1'b0, 5'd0);
        chk(r0 == a0 && r1 == a1, "R6", "8-bit imm 1 vs 7", r0, a0);
        do_op(2'd1, 3'd2, 1'b1, 5'd0); a0 = r0; a1 = r1;
        do_op(2'd1, 3'd6, 1'b1, 5'd0);
        chk(r0 == a0 && r1 == a1, "R6", "16-bit imm 2 vs 6", r1, a1);

        // R9: upper table words have no effect
        for (int s = 0; s < 3; s++) begin
            do_op(2'(s), 3'd3, 1'b0, 5'd4); a0 = r0; a1 = r1;
            tbl[511:128] = ~tbl[511:128];
            do_op(2'(s), 3'd3, 1'b0, 5'd4);
            chk(r0 == a0 && r1 == a1, "R9", "upper words changed", r0 ^ a0, '0);
        end

        // R7: field bit 4 ignored in the adjacent form
        do_op(2'd0, 3'd0, 1'b0, 5'h15);
        chk(d0 == 5'd10 && d1 == 5'd11, "R7", "bit4 ignored", VL'({d0, d1}), VL'({5'd10, 5'd11}));
        // R8: field bit 3 ignored in the spaced form
        do_op(2'd1, 3'd0, 1'b1, 5'h0D);
        chk(d0 == 5'd5 && d1 == 5'd13, "R8", "bit3 ignored", VL'({d0, d1}), VL'({5'd5, 5'd13}));

        // R1: back-to-back starts give done on each following cycle
        @(negedge clk);
        sz = 2'd0; imm = 3'd0; strd = 1'b0; start = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, "R1", "back-to-back first", VL'(done), VL'(1));
        sz = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && undef == 1'b1, "R2", "back-to-back reserved", VL'({done, undef}), VL'(2'b11));
        @(negedge clk);
        chk(done == 1'b0 && undef == 1'b0, "R1", "quiet after burst", VL'({done, undef}), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule